// File: doc/BRIEF.md
# Fault-Tolerant CAN Line Fault Manager

This block is the digital decision core of a low-speed, fault-tolerant CAN line driver. It receives the digitized results of the analog front end: the differential receiver, the per-wire dominant comparators, and the battery-short and soft-short detectors. It also receives the local transmit data and an indication that the driver is in its normal operating state. From these it chooses whether the bus runs differentially or on only one healthy wire. It enables or disables each wire's output stage and termination switch, picks the source of the receive output, and drives an active-low error flag.

Faults that make a wire unusable are confirmed by per-class debounce timers before that wire is switched off. A separate recovery timer for each class decides when the wire is brought back. Faults that differential reception can ride through (a broken or grounded wire seen only as unequal activity) are found by comparing dominant-onset counts of the two wires. These faults are only reported, never isolated. A watchdog on the transmit input cuts both drivers when the local protocol controller holds the bus dominant too long. All timing is in clock cycles. Every input passes through a two-flop synchronizer.

Top module: `can_fault_mgr`

## Requirements
- R1: After synchronous reset the block is in differential mode (`mode_o` = 2'b00). All four enables are high, `nerr_o` is high and all timers and edge counters are cleared. A fault held in isolation before reset is dropped.
- R2: In differential mode `rxd_o` equals `rx_diff_i` two clock cycles after it changes. Low means dominant.
- R3: CANL shorted to battery (`canl_bat_i` high) is confirmed after `DET_CANL_BAT` consecutive cycles. The block then enters CANH-only mode (`mode_o` = 2'b01), clears `drv_l_en_o` and `term_l_en_o`, and drives `rxd_o` as the inverse of `canh_dom_i`.
- R4: Three CANH faults are each confirmed after their own number of consecutive cycles: hard battery short (`canh_bat_i`, `DET_CANH_BAT`), soft battery short (`canh_soft_i`, `DET_CANH_SOFT`), and CANH grounded or shorted to CANL (local transmit dominant, `canl_dom_i` high and `canh_dom_i` low, `DET_CANH_GND`). On confirmation the block enters CANL-only mode (`mode_o` = 2'b10), clears `drv_h_en_o` and `term_h_en_o`, and drives `rxd_o` as the inverse of `canl_dom_i`.
- R5: A fault condition that lasts fewer cycles than its detection count changes neither the mode nor any enable.
- R6: An isolated wire is restored only after its fault condition has been absent for the class recovery count: `REC_CANL_BAT` for CANL, `REC_CANH` for the CANH classes. If the fault reappears, the recovery count restarts.
- R7: When a CANH fault and the CANL fault are both confirmed, CANL-only mode (2'b10) wins. At least one termination stays enabled in every mode.
- R8: The block latches a reported wire fault when the dominant-onset count of one wire leads the other's by `FALL_LIM` (4). A lead of 3 is not reported. The mode is unaffected.
- R9: The edge-mismatch fault clears after `RISE_LIM` (2) recessive onsets that occur on both wires in the same cycle. The report on `nerr_o` is held until the next local transmit dominant onset after that clearing. A transmit onset while the fault is still present does not release it.
- R10: If `txd_i` (low = dominant) stays low for `TX_TIMEOUT` cycles, both `drv_h_en_o` and `drv_l_en_o` go low and `nerr_o` goes low. Both drivers are re-enabled once `txd_i` returns high.
- R11: `nerr_o` goes low only while `normal_i` is high. Isolation still takes place while `normal_i` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| txd_i | input | 1 | Transmit data, low = dominant |
| normal_i | input | 1 | High while the driver is in normal operating mode |
| rx_diff_i | input | 1 | Differential receiver output, low = dominant |
| canh_dom_i | input | 1 | CANH single-ended comparator, high = CANH dominant |
| canl_dom_i | input | 1 | CANL single-ended comparator, high = CANL dominant |
| canh_bat_i | input | 1 | CANH hard short to battery detected |
| canh_soft_i | input | 1 | CANH soft short to battery (mid band) detected |
| canl_bat_i | input | 1 | CANL short to battery detected |
| rxd_o | output | 1 | Receive data to the protocol controller, low = dominant |
| nerr_o | output | 1 | Error flag, low = error |
| drv_h_en_o | output | 1 | CANH output stage enable |
| drv_l_en_o | output | 1 | CANL output stage enable |
| term_h_en_o | output | 1 | CANH termination switch enable |
| term_l_en_o | output | 1 | CANL termination switch enable |
| mode_o | output | 2 | 00 differential, 01 CANH only, 10 CANL only |

## Verification
The bench probes each debounce and recovery window on both sides of its boundary. A design with an off-by-a-few counter, or one that does not restart the count on a brief glitch or a reappearing fault, would switch wires too early or too late. Edge-mismatch detection is driven to a lead of exactly three and then four. A design that either misjudges the threshold or releases the report at the first transmit onset while the fault persists would show the wrong error flag. The double-fault priority, the error-flag gating on the normal-mode input and the transmit watchdog's immediate release are each checked, so that a design which keeps drivers off, flags outside normal mode or picks the wrong surviving wire is caught.

// File: rtl/can_fm_pkg.sv
// Shared types and index constants for the CAN line fault manager.
package can_fm_pkg;

    // Operating mode of the bus line pair.
    typedef enum logic [1:0] {
        MODE_DIFF   = 2'b00,
        MODE_H_ONLY = 2'b01,
        MODE_L_ONLY = 2'b10
    } bus_mode_e;

    // Bit positions inside the synchronized input vector.
    localparam int SI_TXD    = 0;
    localparam int SI_NORMAL = 1;
    localparam int SI_RXDIFF = 2;
    localparam int SI_HDOM   = 3;
    localparam int SI_LDOM   = 4;
    localparam int SI_HBAT   = 5;
    localparam int SI_HSOFT  = 6;
    localparam int SI_LBAT   = 7;
    localparam int SI_WIDTH  = 8;

    // Isolating fault classes; class 0 isolates CANL, the rest isolate CANH.
    localparam int CLS_LBAT  = 0;
    localparam int CLS_HBAT  = 1;
    localparam int CLS_HSOFT = 2;
    localparam int CLS_HGND  = 3;
    localparam int NUM_CLS   = 4;

endpackage

// File: rtl/can_fm_sync.sv
// Two-flop synchronizer for a vector of independent asynchronous bits.
// Assumes each bit is a level that is allowed to be sampled independently.
module can_fm_sync #(
    parameter int               W       = 8,
    parameter logic [W-1:0]     RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] meta_q;
    logic [W-1:0] sync_q;

    // Two-stage capture of the asynchronous inputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= RST_VAL;
            sync_q <= RST_VAL;
        end else begin
            meta_q <= d_i;
            sync_q <= meta_q;
        end
    end

    assign q_o = sync_q;
endmodule

// File: rtl/can_fm_debounce.sv
// Confirms a fault after DET consecutive cycles of its condition and releases
// it after REC consecutive cycles without it. Assumes cond_i is synchronous.
module can_fm_debounce #(
    parameter int DET = 16,
    parameter int REC = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cond_i,
    output logic fault_o
);
    localparam int MAXC = (DET > REC) ? DET : REC;
    localparam int CW   = $clog2(MAXC + 1);

    logic [CW-1:0] cnt_q;
    logic          fault_q;

    // Detection count while healthy, recovery count while isolated.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            fault_q <= 1'b0;
        end else if (!fault_q) begin
            if (cond_i) begin
                if (cnt_q == CW'(DET - 1)) begin
                    fault_q <= 1'b1;
                    cnt_q   <= '0;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end else begin
                cnt_q <= '0;
            end
        end else begin
            if (!cond_i) begin
                if (cnt_q == CW'(REC - 1)) begin
                    fault_q <= 1'b0;
                    cnt_q   <= '0;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end else begin
                cnt_q <= '0;
            end
        end
    end

    assign fault_o = fault_q;

    AST_DET_NEEDS_COND: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fault_q) |-> $past(cond_i)); // R5
    AST_REC_NEEDS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(fault_q) |-> !$past(cond_i)); // R6
endmodule

// File: rtl/can_fm_edges.sv
// Tracks the lead of one wire's dominant onsets over the other's and flags a
// non-isolating wire fault at FALL_LIM; clears after RISE_LIM joint recessive
// onsets. Assumes synchronized per-wire dominant levels.
module can_fm_edges #(
    parameter int FALL_LIM = 4,
    parameter int RISE_LIM = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic h_dom_i,
    input  logic l_dom_i,
    output logic flag_o
);
    localparam int DW = $clog2(FALL_LIM + 1) + 1;
    localparam int RW = $clog2(RISE_LIM + 1);
    localparam logic signed [DW-1:0] LIM_P = DW'(FALL_LIM - 1);
    localparam logic signed [DW-1:0] LIM_F = DW'(FALL_LIM);

    logic                 h_prev_q, l_prev_q;
    logic signed [DW-1:0] diff_q;
    logic [RW-1:0]        rise_q;
    logic                 flag_q;
    logic                 fall_h, fall_l, rise_both, inc, dec;

    assign fall_h    = h_dom_i & ~h_prev_q;
    assign fall_l    = l_dom_i & ~l_prev_q;
    assign rise_both = ~h_dom_i & h_prev_q & ~l_dom_i & l_prev_q;
    assign inc       = fall_h & ~fall_l;
    assign dec       = fall_l & ~fall_h;

    // Previous wire levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            h_prev_q <= 1'b0;
            l_prev_q <= 1'b0;
        end else begin
            h_prev_q <= h_dom_i;
            l_prev_q <= l_dom_i;
        end
    end

    // Onset balance, flag set and joint-recovery counting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            diff_q <= '0;
            rise_q <= '0;
            flag_q <= 1'b0;
        end else if (!flag_q) begin
            if (inc) diff_q <= diff_q + 1'b1;
            else if (dec) diff_q <= diff_q - 1'b1;
            if ((inc && diff_q == LIM_P) || (dec && diff_q == -LIM_P))
                flag_q <= 1'b1;
        end else if (rise_both) begin
            if (rise_q == RW'(RISE_LIM - 1)) begin
                flag_q <= 1'b0;
                rise_q <= '0;
                diff_q <= '0;
            end else begin
                rise_q <= rise_q + 1'b1;
            end
        end
    end

    assign flag_o = flag_q;

    AST_DIFF_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (diff_q <= LIM_F) && (diff_q >= -LIM_F)); // R8
endmodule

// File: rtl/can_fm_txwd.sv
// Stuck-dominant transmit watchdog: raises to_o after LIMIT consecutive
// dominant cycles, drops it as soon as transmit data is recessive.
module can_fm_txwd #(
    parameter int LIMIT = 40
) (
    input  logic clk,
    input  logic rst_n,
    input  logic txd_dom_i,
    output logic to_o
);
    localparam int CW = $clog2(LIMIT + 1);

    logic [CW-1:0] cnt_q;

    // Saturating count of the dominant run, cleared on recessive.
    always_ff @(posedge clk) begin
        if (!rst_n)                           cnt_q <= '0;
        else if (!txd_dom_i)                  cnt_q <= '0;
        else if (cnt_q != CW'(LIMIT))         cnt_q <= cnt_q + 1'b1;
    end

    assign to_o = (cnt_q == CW'(LIMIT));

    AST_TXTO_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        !txd_dom_i |=> !to_o); // R10
    AST_TXTO_NEEDS_DOM: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(to_o) |-> $past(txd_dom_i)); // R10
endmodule

// File: rtl/can_fault_mgr.sv
// Fault manager of a fault-tolerant low-speed CAN line driver. Chooses
// differential or single-wire operation from debounced fault classes, selects
// the receive source, gates drivers and terminations, and raises an active-low
// error flag in normal mode. Assumes all inputs are asynchronous levels.
module can_fault_mgr
    import can_fm_pkg::*;
#(
    parameter int DET_CANL_BAT  = 90000,
    parameter int REC_CANL_BAT  = 22500,
    parameter int DET_CANH_BAT  = 90000,
    parameter int DET_CANH_SOFT = 240000,
    parameter int DET_CANH_GND  = 90000,
    parameter int REC_CANH      = 2750,
    parameter int TX_TIMEOUT    = 125000,
    parameter int FALL_LIM      = 4,
    parameter int RISE_LIM      = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       txd_i,
    input  logic       normal_i,
    input  logic       rx_diff_i,
    input  logic       canh_dom_i,
    input  logic       canl_dom_i,
    input  logic       canh_bat_i,
    input  logic       canh_soft_i,
    input  logic       canl_bat_i,
    output logic       rxd_o,
    output logic       nerr_o,
    output logic       drv_h_en_o,
    output logic       drv_l_en_o,
    output logic       term_h_en_o,
    output logic       term_l_en_o,
    output logic [1:0] mode_o
);
    localparam int DET_TAB [NUM_CLS] = '{DET_CANL_BAT, DET_CANH_BAT, DET_CANH_SOFT, DET_CANH_GND};
    localparam int REC_TAB [NUM_CLS] = '{REC_CANL_BAT, REC_CANH, REC_CANH, REC_CANH};
    localparam logic [SI_WIDTH-1:0] SYNC_RST = SI_WIDTH'(1) << SI_TXD;

    logic [SI_WIDTH-1:0] raw, s;
    logic [NUM_CLS-1:0]  cond, fault;
    logic                txd_dom, txd_dom_q, tx_fall;
    logic                minor_flag, minor_rep_q, tx_to;
    bus_mode_e           mode;

    assign raw[SI_TXD]    = txd_i;
    assign raw[SI_NORMAL] = normal_i;
    assign raw[SI_RXDIFF] = rx_diff_i;
    assign raw[SI_HDOM]   = canh_dom_i;
    assign raw[SI_LDOM]   = canl_dom_i;
    assign raw[SI_HBAT]   = canh_bat_i;
    assign raw[SI_HSOFT]  = canh_soft_i;
    assign raw[SI_LBAT]   = canl_bat_i;

    can_fm_sync #(.W(SI_WIDTH), .RST_VAL(SYNC_RST)) u_sync (
        .clk(clk), .rst_n(rst_n), .d_i(raw), .q_o(s)
    );

    assign txd_dom = ~s[SI_TXD];

    // Per-class fault conditions.
    assign cond[CLS_LBAT]  = s[SI_LBAT];
    assign cond[CLS_HBAT]  = s[SI_HBAT];
    assign cond[CLS_HSOFT] = s[SI_HSOFT];
    assign cond[CLS_HGND]  = txd_dom & s[SI_LDOM] & ~s[SI_HDOM];

    for (genvar g = 0; g < NUM_CLS; g++) begin : g_cls
        can_fm_debounce #(.DET(DET_TAB[g]), .REC(REC_TAB[g])) u_deb (
            .clk(clk), .rst_n(rst_n), .cond_i(cond[g]), .fault_o(fault[g])
        );
    end

    can_fm_edges #(.FALL_LIM(FALL_LIM), .RISE_LIM(RISE_LIM)) u_edges (
        .clk(clk), .rst_n(rst_n), .h_dom_i(s[SI_HDOM]), .l_dom_i(s[SI_LDOM]),
        .flag_o(minor_flag)
    );

    can_fm_txwd #(.LIMIT(TX_TIMEOUT)) u_txwd (
        .clk(clk), .rst_n(rst_n), .txd_dom_i(txd_dom), .to_o(tx_to)
    );

    // Mode selection: a CANH fault takes precedence over the CANL fault.
    always_comb begin
        if (|fault[NUM_CLS-1:1])  mode = MODE_L_ONLY;
        else if (fault[CLS_LBAT]) mode = MODE_H_ONLY;
        else                      mode = MODE_DIFF;
    end

    assign tx_fall = txd_dom & ~txd_dom_q;

    // Holds the edge-mismatch report until a transmit onset after clearing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            txd_dom_q   <= 1'b0;
            minor_rep_q <= 1'b0;
        end else begin
            txd_dom_q <= txd_dom;
            if (minor_flag)            minor_rep_q <= 1'b1;
            else if (tx_fall)          minor_rep_q <= 1'b0;
        end
    end

    // Receive source per mode.
    always_comb begin
        unique case (mode)
            MODE_H_ONLY: rxd_o = ~s[SI_HDOM];
            MODE_L_ONLY: rxd_o = ~s[SI_LDOM];
            default:     rxd_o = s[SI_RXDIFF];
        endcase
    end

    assign mode_o      = mode;
    assign term_h_en_o = (mode != MODE_L_ONLY);
    assign term_l_en_o = (mode != MODE_H_ONLY);
    assign drv_h_en_o  = (mode != MODE_L_ONLY) & ~tx_to;
    assign drv_l_en_o  = (mode != MODE_H_ONLY) & ~tx_to;
    assign nerr_o      = ~(s[SI_NORMAL] & ((mode != MODE_DIFF) | minor_rep_q | tx_to));

    AST_TERM_DRV_L: assert property (@(posedge clk) disable iff (!rst_n)
        !term_l_en_o |-> !drv_l_en_o); // R3
    AST_TERM_DRV_H: assert property (@(posedge clk) disable iff (!rst_n)
        !term_h_en_o |-> !drv_h_en_o); // R4
    AST_ONE_WIRE_LEFT: assert property (@(posedge clk) disable iff (!rst_n)
        term_h_en_o || term_l_en_o); // R7
    AST_REPORT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (minor_rep_q && !tx_fall) |=> minor_rep_q); // R9
endmodule

// File: tb/can_fault_mgr_test.sv
// Directed bench for the CAN line fault manager.
module can_fault_mgr_test;
    localparam int P_DET_LB = 20, P_REC_LB = 40, P_DET_HB = 16, P_DET_HS = 24;
    localparam int P_DET_HG = 12, P_REC_H = 8, P_TXTO = 40;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic txd = 1'b1, normal = 1'b1, rx_diff = 1'b1;
    logic hdom = 1'b0, ldom = 1'b0, hbat = 1'b0, hsoft = 1'b0, lbat = 1'b0;
    logic rxd, nerr, drv_h, drv_l, term_h, term_l;
    logic [1:0] mode;
    int tests = 0, fails = 0;
    bit done = 0;

    always #10 clk = ~clk;

    can_fault_mgr #(
        .DET_CANL_BAT(P_DET_LB), .REC_CANL_BAT(P_REC_LB), .DET_CANH_BAT(P_DET_HB),
        .DET_CANH_SOFT(P_DET_HS), .DET_CANH_GND(P_DET_HG), .REC_CANH(P_REC_H),
        .TX_TIMEOUT(P_TXTO), .FALL_LIM(4), .RISE_LIM(2)
    ) uut (
        .clk(clk), .rst_n(rst_n), .txd_i(txd), .normal_i(normal), .rx_diff_i(rx_diff),
        .canh_dom_i(hdom), .canl_dom_i(ldom), .canh_bat_i(hbat), .canh_soft_i(hsoft),
        .canl_bat_i(lbat), .rxd_o(rxd), .nerr_o(nerr), .drv_h_en_o(drv_h),
        .drv_l_en_o(drv_l), .term_h_en_o(term_h), .term_l_en_o(term_l), .mode_o(mode)
    );

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input string what, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        txd = 1; normal = 1; rx_diff = 1; hdom = 0; ldom = 0;
        hbat = 0; hsoft = 0; lbat = 0;
        rst_n = 0;
        cyc(3);
        rst_n = 1;
        cyc(1);
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1", "mode", mode, 0);
        chk("R1", "enables", {drv_h, drv_l, term_h, term_l}, 4'b1111);
        chk("R1", "nerr", nerr, 1);
        hbat = 1; cyc(P_DET_HB + 4);
        chk("R1", "pre-reset isolation", mode, 2);
        hbat = 0; rst_n = 0; cyc(2);
        chk("R1", "mode in reset", mode, 0);
        rst_n = 1; cyc(1);
        chk("R1", "mode after reset", mode, 0);
    endtask

    task automatic t_diff_rx();
        do_reset();
        rx_diff = 0; cyc(1);
        chk("R2", "rxd one cycle", rxd, 1);
        cyc(1);
        chk("R2", "rxd two cycles", rxd, 0);
        rx_diff = 1; cyc(3);
        chk("R2", "rxd recessive", rxd, 1);
    endtask

    task automatic t_canl_bat();
        do_reset();
        lbat = 1; cyc(P_DET_LB);
        chk("R3", "before detect", mode, 0);
        cyc(4);
        chk("R3", "mode", mode, 1);
        chk("R3", "enables", {drv_h, drv_l, term_h, term_l}, 4'b1010);
        chk("R3", "nerr", nerr, 0);
        rx_diff = 0; hdom = 0; cyc(3);
        chk("R3", "rxd ignores diff", rxd, 1);
        hdom = 1; cyc(3);
        chk("R3", "rxd from canh", rxd, 0);
        hdom = 0;
        lbat = 0; cyc(P_REC_LB);
        chk("R6", "still isolated", mode, 1);
        cyc(4);
        chk("R6", "restored", mode, 0);
    endtask

    task automatic t_canh_bat();
        do_reset();
        hbat = 1; cyc(P_DET_HB);
        chk("R4", "hard before", mode, 0);
        cyc(4);
        chk("R4", "hard mode", mode, 2);
        chk("R4", "hard enables", {drv_h, drv_l, term_h, term_l}, 4'b0101);
        ldom = 1; cyc(3);
        chk("R4", "rxd from canl", rxd, 0);
        ldom = 0; cyc(3);
        chk("R4", "rxd canl recessive", rxd, 1);
        // recovery interrupted by a reappearance
        hbat = 0; cyc(P_REC_H - 4);
        hbat = 1; cyc(2);
        hbat = 0; cyc(P_REC_H - 2);
        chk("R6", "restart recovery", mode, 2);
        cyc(6);
        chk("R6", "canh restored", mode, 0);
    endtask

    task automatic t_canh_soft();
        do_reset();
        hsoft = 1; cyc(P_DET_HS);
        chk("R4", "soft before", mode, 0);
        cyc(4);
        chk("R4", "soft mode", mode, 2);
        hsoft = 0; cyc(P_REC_H + 4);
        chk("R6", "soft restored", mode, 0);
    endtask

    task automatic t_canh_gnd();
        do_reset();
        txd = 0; ldom = 1; hdom = 0; cyc(P_DET_HG);
        chk("R4", "gnd before", mode, 0);
        cyc(4);
        chk("R4", "gnd mode", mode, 2);
        chk("R4", "gnd drv_h", drv_h, 0);
        txd = 1; ldom = 0; cyc(P_REC_H + 4);
        chk("R6", "gnd restored", mode, 0);
    endtask

    task automatic t_glitch();
        do_reset();
        lbat = 1; cyc(P_DET_LB - 3);
        lbat = 0; cyc(P_DET_LB + 5);
        chk("R5", "canl glitch mode", mode, 0);
        hbat = 1; cyc(P_DET_HB - 3);
        hbat = 0; cyc(P_DET_HB + 5);
        chk("R5", "canh glitch enables", {drv_h, drv_l, term_h, term_l}, 4'b1111);
    endtask

    task automatic t_both();
        do_reset();
        lbat = 1; hbat = 1; cyc(P_DET_LB + 4);
        chk("R7", "priority mode", mode, 2);
        chk("R7", "terminations", {term_h, term_l}, 2'b01);
    endtask

    task automatic pulse(input bit h, input bit l);
        hdom = h; ldom = l; cyc(3);
        hdom = 0; ldom = 0; cyc(3);
    endtask

    task automatic t_edges();
        do_reset();
        pulse(0, 1); pulse(0, 1); pulse(0, 1);
        chk("R8", "lead of three", nerr, 1);
        pulse(0, 1); cyc(2);
        chk("R8", "lead of four", nerr, 0);
        chk("R8", "mode unaffected", mode, 0);
        txd = 0; cyc(3); txd = 1; cyc(4);
        chk("R9", "tx onset while present", nerr, 0);
        pulse(1, 1); pulse(1, 1); cyc(2);
        chk("R9", "held after clearing", nerr, 0);
        txd = 0; cyc(3); txd = 1; cyc(4);
        chk("R9", "released at tx onset", nerr, 1);
    endtask

    task automatic t_txwd();
        do_reset();
        txd = 0; cyc(P_TXTO - 4);
        chk("R10", "before timeout", {drv_h, drv_l}, 2'b11);
        cyc(8);
        chk("R10", "drivers cut", {drv_h, drv_l}, 2'b00);
        chk("R10", "nerr", nerr, 0);
        chk("R10", "terms kept", {term_h, term_l}, 2'b11);
        txd = 1; cyc(4);
        chk("R10", "drivers back", {drv_h, drv_l}, 2'b11);
        chk("R10", "nerr back", nerr, 1);
    endtask

    task automatic t_normal_gate();
        do_reset();
        normal = 0; lbat = 1; cyc(P_DET_LB + 4);
        chk("R11", "isolated outside normal", mode, 1);
        chk("R11", "nerr outside normal", nerr, 1);
        normal = 1; cyc(3);
        chk("R11", "nerr in normal", nerr, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            tests++; fails++;
            $display("FAIL watchdog (all requirements): actual=running expected=finished");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_diff_rx();
        t_canl_bat();
        t_canh_bat();
        t_canh_soft();
        t_canh_gnd();
        t_glitch();
        t_both();
        t_edges();
        t_txwd();
        t_normal_gate();
        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule